// File: doc/BRIEF.md
# Constant-Over-Divisor Sequential Divider

This block computes the integer reciprocal ratio floor(2^46 / D) for a 32-bit unsigned divisor D, which is a fixed scaled numerator divided by a value known only at run time. A caller pulses `start` with the divisor on `divisor`. The block raises `busy` while it works and then pulses `done` for one cycle. The 32-bit `quotient` is valid on that cycle and holds until the next accepted start.

The numerator is a single set bit, so the partial remainder does not hold a full dividend. It starts as one bit placed at the divisor's most significant set bit. A restoring shift-and-subtract step then yields one quotient bit per clock. The number of steps follows from the divisor's leading-one position, so quotient bits that are known to be zero are never computed. A divisor whose upper half word is zero, including zero itself, is outside the supported range and returns zero at once.

Top module: `recip_div`

## Requirements
- R1: For any divisor D with D >= 2^16, the quotient presented with `done` equals floor(2^46 / D) taken as a 32-bit unsigned value.
- R2: For a divisor with bits 31..16 all zero (this includes zero), the block does not iterate. It does not raise `busy`, and `done` is high in the cycle right after the edge that samples `start`, with `quotient` equal to 0.
- R3: For an in-range divisor whose highest set bit is at position p (16..31), the block performs n = 47 - p iterations. Exactly 16 of these produce the low half word of the quotient. `done` is high in the cycle that follows the (n+1)-th rising edge, counting the edge that samples `start` as the first.
- R4: `busy` is high from the cycle after an in-range start is sampled until the last iteration, and it is low in the cycle where `done` is high. `busy` and `done` are never high together.
- R5: `done` is a single-cycle pulse. After it, `quotient` keeps its value until the next start is accepted.
- R6: A `start` pulse that arrives while `busy` is high is ignored. Neither the result nor the completion time of the division in progress changes.
- R7: After reset, `busy` and `done` are 0 and `quotient` is 0.
- R8: A power-of-two divisor 2^p gives exactly 2^(46-p). The extremes are 2^16, which gives 2^30, and 0xFFFFFFFF, which gives 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with `divisor`; sampled only while idle |
| divisor | input | 32 | Unsigned divisor D |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse marking a valid `quotient` |
| quotient | output | 32 | floor(2^46 / D), or 0 when out of range |

## Verification
The hardest case to reach from the ports is a second `start` that lands in the middle of an iteration run. That pulse must change neither the result nor the finishing cycle. The bench issues a start carrying a different divisor a few cycles into a run and checks both the quotient and the measured latency against the first divisor. Every leading-one position from 16 to 31 is swept with the divisor at 2^p, 2^p + 1 and 2^(p+1) - 1, so each iteration count and each boundary of the remainder compare is covered. Random divisors and the out-of-range values, including zero, complete the sweep.

// File: rtl/recip_div.sv
module recip_div #(
  parameter int W    = 32,
  parameter int NLOG = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int HALF = W / 2;
  localparam int TOP  = NLOG + W;
  localparam int CW   = $clog2(TOP + 2);
  localparam int LW   = $clog2(W);

  logic [LW-1:0] lead;
  logic          in_range;
  logic [W:0]    rem_q;
  logic [W-1:0]  dvs_q;
  logic [W-1:0]  quo_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [W+1:0]  diff;
  logic          fits;
  logic [W:0]    kept;

  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++)
      if (divisor[i]) lead = LW'(i);
  end

  assign in_range = (|divisor[W-1:HALF]) && (int'(lead) <= TOP);
  assign diff     = {1'b0, rem_q} - {2'b00, dvs_q};
  assign fits     = ~diff[W+1];
  assign kept     = fits ? diff[W:0] : rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start) begin
        quo_q <= '0;
        dvs_q <= divisor;
        if (in_range) begin
          rem_q  <= (W+1)'(1) << lead;
          cnt_q  <= CW'(TOP + 1) - CW'(lead);
          busy_q <= 1'b1;
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        quo_q <= {quo_q[W-2:0], fits};
        rem_q <= {kept[W-1:0], 1'b0};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign quotient = quo_q;
endmodule

// File: rtl/recip_div_chk.sv
module recip_div_chk #(
  parameter int W    = 32,
  parameter int NLOG = 14
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient
);
  localparam int HALF = W / 2;
  localparam int TOP  = NLOG + W;

  a_r2_out_of_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor[W-1:HALF] == '0) |=> (done && !busy && quotient == '0));

  a_r3_in_range_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor[W-1:HALF] != '0) |=> (busy && !done));

  a_r4_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(quotient));

  a_r1_quotient_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (quotient <= (W'(1) << (TOP - HALF))));
endmodule

bind recip_div recip_div_chk #(.W(W), .NLOG(NLOG)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .busy(busy), .done(done), .quotient(quotient)
);

// File: tb/recip_div_tb.sv
module recip_div_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] quotient;
  int vectors = 0;
  int misses  = 0;
  int ticks   = 0;

  always #2.5 clk = ~clk;

  recip_div dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  function automatic logic [31:0] ref_q(logic [31:0] d);
    logic [63:0] num;
    num = 64'd1 << 46;
    if (d[31:16] == 16'd0) return 32'd0;
    return 32'(num / {32'd0, d});
  endfunction

  function automatic int ref_lat(logic [31:0] d);
    int p;
    p = 0;
    for (int i = 0; i < 32; i++) if (d[i]) p = i;
    if (d[31:16] == 16'd0) return 1;
    return 47 - p + 1;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(logic [31:0] d, logic [31:0] intrude, bit poke);
    int k;
    @(negedge clk);
    start = 1'b1;
    divisor = d;
    @(negedge clk);
    start = 1'b0;
    divisor = '0;
    k = 1;
    if (d[31:16] != 16'd0) check("R4 busy after start", 64'(busy), 64'd1);
    while (!done && k < 200) begin
      if (poke && k == 3) begin
        start = 1'b1;
        divisor = intrude;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    check(d[31:16] == 16'd0 ? "R2 quotient" : (poke ? "R6 quotient" : "R1 quotient"),
          64'(quotient), 64'(ref_q(d)));
    check(poke ? "R6 latency" : "R3 latency", 64'(k), 64'(ref_lat(d)));
    check("R4 busy low at done", 64'(busy), 64'd0);
    @(negedge clk);
    check("R5 done one cycle", 64'(done), 64'd0);
    check("R5 quotient held", 64'(quotient), 64'(ref_q(d)));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      ticks++;
      if (ticks > 150000) begin
        misses++;
        $display("FAIL watchdog: actual %0d expected below 150000", ticks);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 busy", 64'(busy), 64'd0);
    check("R7 done", 64'(done), 64'd0);
    check("R7 quotient", 64'(quotient), 64'd0);
    rst_n = 1'b1;
    run(32'h0001_0000, 0, 0);
    check("R8 max at 2^16", 64'(quotient), 64'h4000_0000);
    run(32'hFFFF_FFFF, 0, 0);
    check("R8 all ones", 64'(quotient), 64'd16384);
    run(32'h8000_0000, 0, 0);
    check("R8 2^31", 64'(quotient), 64'h8000);
    for (int p = 16; p < 32; p++) begin
      run(32'd1 << p, 0, 0);
      check("R8 power of two", 64'(quotient), 64'd1 << (46 - p));
      run((32'd1 << p) + 32'd1, 0, 0);
      run(32'((64'd1 << (p + 1)) - 1), 0, 0);
    end
    run(32'd0, 0, 0);
    run(32'd1, 0, 0);
    run(32'h0000_FFFF, 0, 0);
    run(32'h0000_8000, 0, 0);
    for (int i = 0; i < 300; i++) run($urandom, 0, 0);
    for (int i = 0; i < 40; i++) run($urandom | 32'h0001_0000, 32'h0000_0000, 0);
    for (int i = 0; i < 40; i++) run($urandom | 32'h0001_0000, $urandom, 1);
    run(32'h0001_0000, 32'h0000_0001, 1);
    run(32'h1234_5678, 32'h0001_0000, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule